// File: doc/BRIEF.md
# Centre-Aligned PWM Up/Down Timer

This block is an 8-bit timer with one compare channel. It counts up from zero to its top value, turns around, and counts back down. The result is a symmetric, centre-aligned PWM waveform of the kind used to drive motors. An external prescaler advances the count by pulsing a tick enable. One complete up/down sweep takes 510 ticks, so the output frequency is the prescaled clock divided by 510.

Software writes a new duty value into a holding register at any time. The timer copies that value into the compare register it actually uses only when the count reaches its top value, so a period never mixes two duty values. A 2-bit mode input selects the output behaviour:

- Values 0 and 1 freeze the output.
- Value 2 gives non-inverted PWM.
- Value 3 gives inverted PWM.

Two sticky flags report compare matches and arrivals at the bottom of the count. Each flag has its own write-one-to-clear input.

Top module: `pwm_phase_timer`

## Requirements
- R1: While reset is high, and directly after it, the count is 0 and counts upward, `pwm_out` is low, both flags are clear, and both the holding and the active compare registers are 0.
- R2: On each tick the count steps through the sequence 0, 1, …, 255, 254, …, 1, 0, 1, …. The top value 255 is held for exactly one tick, and a full sweep lasts 510 ticks.
- R3: When `tick_en` is low, the count, the direction, `pwm_out` and the flag set events do not change. Only flag clears take effect on such a cycle.
- R4: `ovf_flag` becomes set after the tick edge that brings the count to 0.
- R5: When `out_mode` is 2, a compare match drives `pwm_out` as follows:
  - at count 255 it sets the output high;
  - at count 0 it sets the output low;
  - at any other count it clears the output while counting up and sets it while counting down.
  With a steady compare value k, the output is high for 2·k ticks of each 510-tick sweep.
- R6: When `out_mode` is 3, the output level is the complement of what mode 2 would drive on each match. With compare value 100 the output is high for 310 ticks of each sweep.
- R7: When `out_mode` is 0 or 1, `pwm_out` keeps its value whatever the count or compare matches do.
- R8: `cmp_flag` becomes set after a tick on which the count equals the active compare value.
- R9: A write (`cmp_wr` high) stores `cmp_wdata` in the holding register only. The active compare value takes the holding value on the tick that brings the count to 255.
- R10: A clear input high on any cycle clears its flag. If a set event for the same flag occurs in that cycle, the flag ends up set.
- R11: In mode 2, compare value 0 keeps `pwm_out` low for the whole sweep and compare value 255 keeps it high for the whole sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer tick from the external prescaler |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | New compare value |
| out_mode | input | 2 | Output mode: 0/1 hold, 2 non-inverted, 3 inverted |
| cmp_flag_clr | input | 1 | Write-one-to-clear for the compare-match flag |
| ovf_flag_clr | input | 1 | Write-one-to-clear for the bottom flag |
| pwm_out | output | 1 | PWM waveform |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky bottom-reached flag |

## Verification
Count errors show up in two ways. A wrong turnaround or a skipped value shifts the bottom flag away from its 510-tick spacing within one sweep. A wrong direction bit swaps the set and clear actions, which shows on `pwm_out` at the next compare match, at most one sweep later. A holding register that loads the active value at the wrong time changes the duty of the very sweep in which the new value was written, so the high-tick count of that sweep reveals it. A bench model that follows the timer tick by tick compares all three outputs on every cycle, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD_A = 2'd0,
        MODE_HOLD_B = 2'd1,
        MODE_NONINV = 2'd2,
        MODE_INV    = 2'd3
    } pwm_mode_e;

    localparam int FLAG_CMP = 0;
    localparam int FLAG_BOT = 1;
    localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/pwm_pc_counter.sv
module pwm_pc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             up,
    output logic             at_top,
    output logic             at_bottom
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        at_top    = 1'b0;
        at_bottom = 1'b0;
        if (tick) begin
            if (st_q.up) begin
                if (st_q.cnt == TOP) begin
                    st_d.cnt = TOP - 1'b1;
                    st_d.up  = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == BOT) begin
                    st_d.cnt = BOT + 1'b1;
                    st_d.up  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            at_top    = (st_d.cnt == TOP);
            at_bottom = (st_d.cnt == BOT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= BOT;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign up  = st_q.up;
endmodule

// File: rtl/pwm_pc_compare.sv
module pwm_pc_compare
    import pwm_pc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  pwm_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic             load,
    output logic             pwm,
    output logic             hit,
    output logic [CNT_W-1:0] active
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
        logic             out;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       drive_hi;

    always_comb begin
        st_d     = st_q;
        hit      = tick && (cnt == st_q.active);
        drive_hi = 1'b0;
        if (load) begin
            st_d.active = st_q.shadow;
        end
        if (wr_en) begin
            st_d.shadow = wr_val;
        end
        if (cnt == TOP) begin
            drive_hi = 1'b1;
        end else if (cnt == BOT) begin
            drive_hi = 1'b0;
        end else begin
            drive_hi = ~up;
        end
        if (hit) begin
            case (mode)
                MODE_NONINV: st_d.out = drive_hi;
                MODE_INV:    st_d.out = ~drive_hi;
                default:     st_d.out = st_q.out;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm    = st_q.out;
    assign active = st_q.active;
endmodule

// File: rtl/pwm_pc_flag.sv
module pwm_pc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = set | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
    import pwm_pc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       out_mode,
    input  logic             cmp_flag_clr,
    input  logic             ovf_flag_clr,
    output logic             pwm_out,
    output logic             cmp_flag,
    output logic             ovf_flag
);
    logic [CNT_W-1:0]     cnt_w;
    logic [CNT_W-1:0]     active_w;
    logic                 up_w;
    logic                 top_w;
    logic                 bot_w;
    logic                 hit_w;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    pwm_mode_e            mode_w;

    assign mode_w = pwm_mode_e'(out_mode);

    pwm_pc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .cnt       (cnt_w),
        .up        (up_w),
        .at_top    (top_w),
        .at_bottom (bot_w)
    );

    pwm_pc_compare #(.CNT_W(CNT_W)) u_compare (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .wr_en  (cmp_wr),
        .wr_val (cmp_wdata),
        .mode   (mode_w),
        .cnt    (cnt_w),
        .up     (up_w),
        .load   (top_w),
        .pwm    (pwm_out),
        .hit    (hit_w),
        .active (active_w)
    );

    assign flag_set[FLAG_CMP] = hit_w;
    assign flag_set[FLAG_BOT] = bot_w;
    assign flag_clr[FLAG_CMP] = cmp_flag_clr;
    assign flag_clr[FLAG_BOT] = ovf_flag_clr;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        pwm_pc_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (flag_set[i]),
            .clr  (flag_clr[i]),
            .flag (flag_q[i])
        );
    end

    assign cmp_flag = flag_q[FLAG_CMP];
    assign ovf_flag = flag_q[FLAG_BOT];
endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic [1:0]       out_mode,
    input logic             pwm_out,
    input logic             cmp_flag,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] active
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    assert_idle_cnt_R3: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

    assert_idle_pwm_R3: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(pwm_out));

    assert_top_turn_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && cnt == TOP) |=> (cnt == TOP - 1'b1));

    assert_bottom_turn_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && cnt == BOT) |=> (cnt == BOT + 1'b1));

    assert_bottom_flag_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (cnt == BOT));

    assert_match_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> ($past(tick_en) && $past(cnt) == $past(active)));

    assert_hold_mode_R7: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] == 1'b0) |=> $stable(pwm_out));

    assert_load_at_top_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> (cnt == TOP));
endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .out_mode (out_mode),
    .pwm_out  (pwm_out),
    .cmp_flag (cmp_flag),
    .ovf_flag (ovf_flag),
    .cnt      (cnt_w),
    .active   (active_w)
);

// File: tb/pwm_phase_timer_bench.sv
module pwm_phase_timer_bench;
    localparam int TOPV = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic [1:0] out_mode = 2'd2;
    logic       cmp_flag_clr = 1'b0;
    logic       ovf_flag_clr = 1'b0;
    logic       pwm_out;
    logic       cmp_flag;
    logic       ovf_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_cnt = 0;
    bit m_up = 1;
    int m_sh = 0;
    int m_act = 0;
    bit m_out = 0;
    bit m_cf = 0;
    bit m_of = 0;
    logic [1:0] cur_mode = 2'd2;

    always #4 clk = ~clk;

    pwm_phase_timer u_pwm_phase_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .cmp_wr       (cmp_wr),
        .cmp_wdata    (cmp_wdata),
        .out_mode     (out_mode),
        .cmp_flag_clr (cmp_flag_clr),
        .ovf_flag_clr (ovf_flag_clr),
        .pwm_out      (pwm_out),
        .cmp_flag     (cmp_flag),
        .ovf_flag     (ovf_flag)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit level_for(int c, bit up);
        if (c == TOPV) return 1'b1;
        if (c == 0) return 1'b0;
        return !up;
    endfunction

    task automatic model_step(bit t, bit wr, int wd, logic [1:0] md, bit cc, bit co);
        int nc;
        bit nu;
        bit hit;
        bit nof;
        nc  = m_cnt;
        nu  = m_up;
        hit = t && (m_cnt == m_act);
        if (t) begin
            if (m_up) begin
                if (m_cnt == TOPV) begin nc = TOPV - 1; nu = 0; end
                else nc = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin nc = 1; nu = 1; end
                else nc = m_cnt - 1;
            end
        end
        if (hit && md[1]) begin
            m_out = (md == 2'd2) ? level_for(m_cnt, m_up) : !level_for(m_cnt, m_up);
        end
        nof = t && (nc == 0);
        if (t && nc == TOPV) m_act = m_sh;
        if (wr) m_sh = wd;
        m_cf  = hit | (m_cf & !cc);
        m_of  = nof | (m_of & !co);
        m_cnt = nc;
        m_up  = nu;
    endtask

    task automatic cyc(bit t, bit wr, int wd, bit cc, bit co);
        tick_en      = t;
        cmp_wr       = wr;
        cmp_wdata    = wd[7:0];
        out_mode     = cur_mode;
        cmp_flag_clr = cc;
        ovf_flag_clr = co;
        model_step(t, wr, wd, cur_mode, cc, co);
        @(negedge clk);
        chk(pwm_out === m_out, "R5 R6 R7 R9 R11 pwm_out", int'(pwm_out), int'(m_out));
        chk(cmp_flag === m_cf, "R8 R10 cmp_flag", int'(cmp_flag), int'(m_cf));
        chk(ovf_flag === m_of, "R4 R10 ovf_flag", int'(ovf_flag), int'(m_of));
    endtask

    task automatic wait_bottom();
        cyc(1, 0, 0, 0, 1);
        for (int n = 0; n < 600; n++) begin
            if (ovf_flag) break;
            cyc(1, 0, 0, 0, 0);
        end
    endtask

    task automatic duty(logic [1:0] md, int k, int exp, string tag);
        int hi;
        cur_mode = md;
        cyc(0, 1, k, 0, 0);
        wait_bottom();
        wait_bottom();
        hi = 0;
        for (int n = 0; n < 510; n++) begin
            cyc(1, 0, 0, 0, 0);
            if (pwm_out) hi++;
        end
        chk(hi == exp, tag, hi, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int n;
        int hi;
        bit p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs while held in reset
        chk(pwm_out === 1'b0 && cmp_flag === 1'b0 && ovf_flag === 1'b0,
            "R1 reset outputs", int'({pwm_out, cmp_flag, ovf_flag}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_out === 1'b0 && cmp_flag === 1'b0 && ovf_flag === 1'b0,
            "R1 after reset", int'({pwm_out, cmp_flag, ovf_flag}), 0);

        // R2 and R4: first bottom arrives after 510 ticks from reset
        n = 0;
        for (int i = 0; i < 600; i++) begin
            cyc(1, 0, 0, 0, 0);
            n++;
            if (ovf_flag) break;
        end
        chk(n == 510, "R2 R4 ticks to first bottom", n, 510);
        cyc(0, 0, 0, 0, 1);
        chk(ovf_flag === 1'b0, "R10 clear bottom flag", int'(ovf_flag), 0);

        // Duty corner cases
        duty(2'd2, 0,   0,   "R11 compare 0 stays low");
        duty(2'd2, 255, 510, "R11 compare 255 stays high");
        duty(2'd3, 100, 310, "R6 inverted duty k=100");
        duty(2'd2, 37,  74,  "R5 non-inverted duty k=37");
        duty(2'd2, 100, 200, "R5 non-inverted duty k=100");

        // R9: a write at the bottom takes effect only from the next top
        wait_bottom();
        hi = 0;
        cyc(1, 1, 200, 0, 0);
        if (pwm_out) hi++;
        for (int i = 0; i < 509; i++) begin
            cyc(1, 0, 0, 0, 0);
            if (pwm_out) hi++;
        end
        chk(hi == 300, "R9 buffered load at top", hi, 300);

        // R10 and R8: clear held high; each match still sets the flag
        wait_bottom();
        n = 0;
        for (int i = 0; i < 510; i++) begin
            cyc(1, 0, 0, 1, 0);
            if (cmp_flag) n++;
        end
        chk(n == 2, "R8 R10 set wins over clear", n, 2);

        // R3: no tick, nothing moves
        p = pwm_out;
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0);
        chk(pwm_out == p, "R3 output held without tick", int'(pwm_out), int'(p));

        // R3: ticks with gaps still give a 510-tick sweep
        wait_bottom();
        cyc(0, 0, 0, 0, 1);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            bit t;
            t = ($urandom % 2) == 1;
            cyc(t, 0, 0, 0, 0);
            if (t) n++;
            if (ovf_flag) break;
        end
        chk(n == 510, "R3 sweep length with sparse ticks", n, 510);

        // R7: hold modes freeze the output
        for (int md = 0; md < 2; md++) begin
            cur_mode = md[1:0];
            p = pwm_out;
            for (int i = 0; i < 600; i++) cyc(1, (i % 97) == 0, $urandom % 256, 0, 0);
            chk(pwm_out == p, "R7 hold mode output", int'(pwm_out), int'(p));
        end

        // Random mix against the model
        for (int i = 0; i < 6000; i++) begin
            int wd;
            int sel;
            if ((i % 400) == 0) cur_mode = 2'($urandom % 4);
            sel = $urandom % 8;
            wd = (sel == 0) ? 0 : (sel == 1) ? 255 : int'($urandom % 256);
            cyc(($urandom % 10) < 7, ($urandom % 12) == 0, wd,
                ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        done = 1;
        finish_run();
    end
endmodule